// File: doc/BRIEF.md
# Start-up Reset Sequencer with Option Loader

This block controls how a small microcontroller leaves reset. It watches an active-low external reset pin and a hold pin, and samples both on an instruction-cycle tick. A reset is taken only after the pin has been low for a qualifying number of ticks. While reset is in force, every pad is held in open-drain configuration with its output floating. The two lowest ports are the exception: they drive a level that comes from the option memory.

When the reset pin goes high, the block opens a window of eight ticks. During that window it reads eight option bytes from a byte-wide configuration memory, one byte per tick, in ascending address order starting at a fixed base address. Each byte is applied as soon as it is latched: per-pin pull-up or open-drain selection, port release from floating, the watchdog enable, the oscillator selection and the after-reset port levels. Any reserved option bit that reads as 1 raises a sticky error flag. At the end of the window the CPU is released with a one-cycle start pulse, which loads its program counter with zero. If the reset pin is low again at that moment, the whole sequence starts over.

The block also tracks the low-power hold mode. Hold is entered when a hold instruction executes while the hold pin is low, and it ends when the hold pin returns high. A reset raised during hold counts only if hold ends before the reset pin is released. Otherwise the reset is dropped and the part stays in hold.

Top module: `boot_seq`

## Requirements
- R1: A reset is taken only after `reset_pin_ni` has been sampled low on 3 consecutive ticks; `cpu_run_o` drops on the clock after the third such tick. A low pulse seen on fewer ticks has no effect on any output.
- R2: While in reset, `pin_pu_o` is all 0 (open-drain) and `port_float_o` is 8'hFC. Ports are ordered bit0=P0, bit1=P1, bit2=P2, bit3=P3, bit4=P4, bit5=P5, bit6=P6, bit7=PC. On every tick in reset, `p0_level_o` takes bit 1 and `p1_level_o` takes bit 2 of the option byte at the base address.
- R3: On the tick at which the reset pin is seen high, an 8-tick window starts. On its k-th tick (k = 0..7) the byte at `OPT_BASE`+k is latched. `opt_rd_o` is high throughout reset and the window, and `opt_addr_o` equals `OPT_BASE` while in reset.
- R4: `pin_pu_o` index i takes its value from one option byte, 1 meaning pull-up and 0 meaning open-drain. Indices 0..7 come from byte 1, bits 0..7. Indices 8..14 come from byte 2, bits 0..6. Indices 15..22 come from byte 3, bits 0..7. Indices 23..26 come from byte 4, bits 0..3. Indices 27..28 come from byte 7, bits 2..3. Each bit takes effect on the tick its byte is latched.
- R5: Byte 0 sets `wdt_en_o` from bit 0, `p0_level_o` from bit 1, `p1_level_o` from bit 2 and `osc_sel_o` from bit 4, all on its latch tick. `wdt_en_o` is 0 while in reset.
- R6: A 1 read in any reserved bit sets `cfg_err_o`. The reserved masks are: byte 0 8'hE8, byte 2 8'h80, byte 4 8'hF0, bytes 5 and 6 8'hFF, byte 7 8'hF3. The flag stays set until the next reset and is 0 while in reset.
- R7: If the reset pin is high on the last window tick, `cpu_run_o` rises on the next clock and `cpu_start_o` is high for exactly that one clock.
- R8: If the reset pin is low on the last window tick, the block returns to reset and no start pulse is issued.
- R9: While running, a tick with `hold_instr_i` high and `hold_pin_ni` low enters hold: `hold_o` rises and `cpu_run_o` falls. A tick with `hold_pin_ni` high resumes running without a start pulse. A hold instruction with the hold pin high has no effect.
- R10: A reset qualified during hold is taken only if a tick sees the hold pin high while the reset pin is still low. If a tick sees the reset pin high first, the block stays in hold and the port configuration is kept.
- R11: `opt_addr_o` never leaves the range `OPT_BASE` to `OPT_BASE`+7 while `opt_rd_o` is high.
- R12: Port float bits for P2..PC clear on the tick their byte is latched: P2 and P3 with byte 2, P4 and P5 with byte 3, P6 with byte 4, PC with byte 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-clock strobe per instruction cycle |
| reset_pin_ni | input | 1 | External reset pin, active low |
| hold_pin_ni | input | 1 | Hold pin, low requests hold |
| hold_instr_i | input | 1 | Hold instruction executed |
| opt_rd_o | output | 1 | Option memory read enable |
| opt_addr_o | output | ADDR_W | Option memory address |
| opt_data_i | input | 8 | Option memory read data (same-cycle) |
| pin_pu_o | output | 29 | Per-pin output mode, 1 pull-up, 0 open-drain |
| port_float_o | output | 8 | Per-port output float (high-Z) |
| p0_level_o | output | 1 | Level driven on P0 after reset |
| p1_level_o | output | 1 | Level driven on P1 after reset |
| wdt_en_o | output | 1 | Watchdog enable |
| osc_sel_o | output | 1 | Oscillator type selection |
| cfg_err_o | output | 1 | Sticky reserved-bit error |
| hold_o | output | 1 | Block is in hold mode |
| cpu_run_o | output | 1 | CPU allowed to execute |
| cpu_start_o | output | 1 | One-clock pulse: start CPU at address zero |

## Verification
On every clock, the bound checker confirms several properties. The option address stays in range and rises by one per window tick. Float bits only ever clear inside the window. The watchdog is off whenever the base byte is on the bus. The error flag clears only during reset. A start pulse is single, falls inside the run state and needs the reset pin high on its final tick. Hold never coexists with run. Other behaviour needs the bench scenarios, where a behavioural model is compared every clock: rejection of 2-tick pulses, the bit-to-pin mapping of real option patterns, a window that restarts because the pin fell low again, and the two outcomes of a reset raised during hold.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam int N_OPT  = 8;
  localparam int IDX_W  = $clog2(N_OPT);
  localparam int N_PIN  = 29;
  localparam int N_PORT = 8;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HOLD,
    ST_HRST,   // reset qualified while in hold, waiting on hold exit
    ST_RST,
    ST_LOAD
  } seq_st_e;

  // option byte that carries pin i
  function automatic int pin_byte(input int i);
    if (i < 8)       return 1;
    else if (i < 15) return 2;
    else if (i < 23) return 3;
    else if (i < 27) return 4;
    else             return 7;
  endfunction

  // bit within that byte
  function automatic int pin_bit(input int i);
    if (i < 8)       return i;
    else if (i < 15) return i - 8;
    else if (i < 23) return i - 15;
    else if (i < 27) return i - 23;
    else             return i - 25;
  endfunction

  // option byte that releases port p from float
  function automatic int port_byte(input int p);
    case (p)
      0, 1:    return 1;
      2, 3:    return 2;
      4, 5:    return 3;
      6:       return 4;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] res_mask(input logic [IDX_W-1:0] b);
    case (b)
      3'd0:    return 8'hE8;
      3'd2:    return 8'h80;
      3'd4:    return 8'hF0;
      3'd5:    return 8'hFF;
      3'd6:    return 8'hFF;
      3'd7:    return 8'hF3;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/boot_rst_qual.sv
module boot_rst_qual #(
  parameter int unsigned QUAL_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_ni,
  output logic qual_o
);
  localparam int CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (tick_i) begin
      if (pin_ni)         cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             qual_i,
  input  logic             rst_pin_ni,
  input  logic             hold_pin_ni,
  input  logic             hold_instr_i,
  output seq_st_e          st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             start_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_OPT - 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             start_q, start_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (qual_i) st_d = ST_RST;
        else if (tick_i && hold_instr_i && !hold_pin_ni) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (qual_i) st_d = ST_HRST;
        else if (tick_i && hold_pin_ni) st_d = ST_RUN;
      end
      ST_HRST: begin
        if (tick_i) begin
          if (rst_pin_ni)       st_d = ST_HOLD;  // reset released first: dropped
          else if (hold_pin_ni) st_d = ST_RST;   // hold ended first: reset taken
        end
      end
      ST_RST: begin
        idx_d = '0;
        if (tick_i && rst_pin_ni) st_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (tick_i) begin
          if (idx_q == IDX_LAST) begin
            if (!rst_pin_ni) st_d = ST_RST;
            else begin
              st_d    = ST_RUN;
              start_d = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_RST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RST;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      start_q <= start_d;
    end
  end

  assign st_o    = st_q;
  assign idx_o   = idx_q;
  assign start_o = start_q;
endmodule

// File: rtl/boot_opt_apply.sv
module boot_opt_apply
  import boot_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  seq_st_e           st_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        data_i,
  output logic [N_PIN-1:0]  pin_pu_o,
  output logic [N_PORT-1:0] port_float_o,
  output logic              p0_level_o,
  output logic              p1_level_o,
  output logic              wdt_en_o,
  output logic              osc_sel_o,
  output logic              cfg_err_o
);
  logic in_rst, ld, ld_base;
  logic [N_PIN-1:0]  pu_q;
  logic [N_PORT-1:0] flt_q, flt_def;
  logic lv0_q, lv1_q, wdt_q, osc_q, err_q;

  assign in_rst  = (st_i == ST_RST);
  assign ld      = (st_i == ST_LOAD) && tick_i;
  assign ld_base = ld && (idx_i == '0);

  for (genvar gi = 0; gi < N_PIN; gi++) begin : g_pin
    localparam int PB = pin_byte(gi);
    localparam int PK = pin_bit(gi);
    logic b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          b_q <= 1'b0;
      else if (in_rst)                      b_q <= 1'b0;
      else if (ld && idx_i == IDX_W'(PB))   b_q <= data_i[PK];
    end
    assign pu_q[gi] = b_q;
  end

  for (genvar gp = 0; gp < N_PORT; gp++) begin : g_port
    localparam int  PB  = port_byte(gp);
    localparam logic DEF = (PB != 1);  // ports driven by a reset level never float
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          f_q <= DEF;
      else if (in_rst)                      f_q <= DEF;
      else if (ld && idx_i == IDX_W'(PB))   f_q <= 1'b0;
    end
    assign flt_q[gp]   = f_q;
    assign flt_def[gp] = DEF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv0_q <= 1'b0;
      lv1_q <= 1'b0;
      wdt_q <= 1'b0;
      osc_q <= 1'b0;
      err_q <= 1'b0;
    end else if (in_rst) begin
      wdt_q <= 1'b0;
      err_q <= 1'b0;
      if (tick_i) begin
        lv0_q <= data_i[1];
        lv1_q <= data_i[2];
      end
    end else if (ld) begin
      if (ld_base) begin
        wdt_q <= data_i[0];
        lv0_q <= data_i[1];
        lv1_q <= data_i[2];
        osc_q <= data_i[4];
      end
      if ((data_i & res_mask(idx_i)) != 8'h00) err_q <= 1'b1;
    end
  end

  // reset state forced at once, not one clock after entry
  assign pin_pu_o     = in_rst ? '0 : pu_q;
  assign port_float_o = in_rst ? flt_def : flt_q;
  assign wdt_en_o     = wdt_q & ~in_rst;
  assign cfg_err_o    = err_q & ~in_rst;
  assign p0_level_o   = lv0_q;
  assign p1_level_o   = lv1_q;
  assign osc_sel_o    = osc_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 14,
  parameter logic [ADDR_W-1:0]    OPT_BASE = 'h2000,
  parameter int unsigned          QUAL_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reset_pin_ni,
  input  logic              hold_pin_ni,
  input  logic              hold_instr_i,
  output logic              opt_rd_o,
  output logic [ADDR_W-1:0] opt_addr_o,
  input  logic [7:0]        opt_data_i,
  output logic [N_PIN-1:0]  pin_pu_o,
  output logic [N_PORT-1:0] port_float_o,
  output logic              p0_level_o,
  output logic              p1_level_o,
  output logic              wdt_en_o,
  output logic              osc_sel_o,
  output logic              cfg_err_o,
  output logic              hold_o,
  output logic              cpu_run_o,
  output logic              cpu_start_o
);
  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic             qual;

  boot_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pin_ni (reset_pin_ni),
    .qual_o (qual)
  );

  boot_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .qual_i       (qual),
    .rst_pin_ni   (reset_pin_ni),
    .hold_pin_ni  (hold_pin_ni),
    .hold_instr_i (hold_instr_i),
    .st_o         (st),
    .idx_o        (idx),
    .start_o      (cpu_start_o)
  );

  boot_opt_apply u_apply (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .st_i         (st),
    .idx_i        (idx),
    .data_i       (opt_data_i),
    .pin_pu_o     (pin_pu_o),
    .port_float_o (port_float_o),
    .p0_level_o   (p0_level_o),
    .p1_level_o   (p1_level_o),
    .wdt_en_o     (wdt_en_o),
    .osc_sel_o    (osc_sel_o),
    .cfg_err_o    (cfg_err_o)
  );

  assign opt_rd_o   = (st == ST_RST) || (st == ST_LOAD);
  assign opt_addr_o = OPT_BASE + ADDR_W'((st == ST_LOAD) ? idx : '0);
  assign hold_o     = (st == ST_HOLD) || (st == ST_HRST);
  assign cpu_run_o  = (st == ST_RUN);
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
  import boot_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 14,
  parameter logic [ADDR_W-1:0] OPT_BASE = 'h2000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              reset_pin_ni,
  input logic              opt_rd_o,
  input logic [ADDR_W-1:0] opt_addr_o,
  input logic [N_PORT-1:0] port_float_o,
  input logic              wdt_en_o,
  input logic              cfg_err_o,
  input logic              hold_o,
  input logic              cpu_run_o,
  input logic              cpu_start_o,
  input seq_st_e           st_i
);
  logic in_load;
  assign in_load = (st_i == ST_LOAD);

  a_r11_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_rd_o |-> (opt_addr_o - OPT_BASE) < ADDR_W'(N_OPT));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_load && $past(in_load) && $past(tick_i)) |-> opt_addr_o == $past(opt_addr_o) + ADDR_W'(1));

  a_r12_float_falls_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_load && $past(in_load)) |-> (port_float_o & ~$past(port_float_o)) == '0);

  a_r5_wdt_off_at_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_rd_o && opt_addr_o == OPT_BASE) |-> !wdt_en_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !opt_rd_o) |=> (cfg_err_o || opt_rd_o));

  a_r7_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_start_o |=> !cpu_start_o);

  a_r7_start_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_start_o |-> (cpu_run_o && $past(opt_rd_o)));

  a_r8_start_pin_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_start_o |-> $past(reset_pin_ni));

  a_r9_hold_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !cpu_run_o);

  a_r1_run_drop_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_run_o) |-> (hold_o || (opt_rd_o && opt_addr_o == OPT_BASE)));
endmodule

bind boot_seq boot_seq_chk #(.ADDR_W(ADDR_W), .OPT_BASE(OPT_BASE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .reset_pin_ni (reset_pin_ni),
  .opt_rd_o     (opt_rd_o),
  .opt_addr_o   (opt_addr_o),
  .port_float_o (port_float_o),
  .wdt_en_o     (wdt_en_o),
  .cfg_err_o    (cfg_err_o),
  .hold_o       (hold_o),
  .cpu_run_o    (cpu_run_o),
  .cpu_start_o  (cpu_start_o),
  .st_i         (st)
);

// File: tb/boot_seq_bench.sv
`timescale 1ns/1ps
module boot_seq_bench;
  localparam int CLK = 20;
  localparam int TDIV = 4;
  localparam int BASE = 'h2000;

  logic clk_i = 1'b0;
  logic rst_ni, tick_i, reset_pin_ni, hold_pin_ni, hold_instr_i;
  logic opt_rd_o, p0_level_o, p1_level_o, wdt_en_o, osc_sel_o, cfg_err_o;
  logic hold_o, cpu_run_o, cpu_start_o;
  logic [13:0] opt_addr_o;
  logic [7:0]  opt_data_i;
  logic [28:0] pin_pu_o;
  logic [7:0]  port_float_o;
  logic [7:0]  mem [8];

  int n_chk = 0, n_bad = 0, n_start = 0;
  bit done = 0;

  always #(CLK/2) clk_i = ~clk_i;

  boot_seq u_boot_seq (.*);

  always_comb begin
    opt_data_i = 8'h00;
    if (opt_addr_o >= 14'(BASE) && opt_addr_o < 14'(BASE + 8))
      opt_data_i = mem[opt_addr_o[2:0]];
  end

  // requirement tables written from the spec
  function automatic int t_byte(int i);
    if (i <= 7) return 1; if (i <= 14) return 2; if (i <= 22) return 3;
    if (i <= 26) return 4; return 7;
  endfunction
  function automatic int t_bit(int i);
    if (i <= 7) return i; if (i <= 14) return i - 8; if (i <= 22) return i - 15;
    if (i <= 26) return i - 23; return i - 25;
  endfunction
  function automatic int t_pbyte(int p);
    if (p <= 1) return 1; if (p <= 3) return 2; if (p <= 5) return 3;
    if (p == 6) return 4; return 7;
  endfunction
  function automatic logic [7:0] t_res(int b);
    case (b) 0: return 8'hE8; 2: return 8'h80; 4: return 8'hF0;
      5, 6: return 8'hFF; 7: return 8'hF3; default: return 8'h00; endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: 0 run, 1 hold, 2 hold+reset pending, 3 reset, 4 window
  int m_st, m_cnt, m_idx;
  logic [28:0] m_pu;
  logic [7:0]  m_flt;
  logic m_lv0, m_lv1, m_wdt, m_osc, m_err, m_start;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_st = 3; m_cnt = 0; m_idx = 0; m_pu = '0; m_flt = 8'hFC;
      m_lv0 = 0; m_lv1 = 0; m_wdt = 0; m_osc = 0; m_err = 0; m_start = 0;
    end else begin
      bit qual;
      logic [7:0] b;
      qual = (m_cnt == 3);
      m_start = 0;
      case (m_st)
        0: if (qual) m_st = 3; else if (tick_i && hold_instr_i && !hold_pin_ni) m_st = 1;
        1: if (qual) m_st = 2; else if (tick_i && hold_pin_ni) m_st = 0;
        2: if (tick_i) begin if (reset_pin_ni) m_st = 1; else if (hold_pin_ni) m_st = 3; end
        3: begin
          m_pu = '0; m_flt = 8'hFC; m_wdt = 0; m_err = 0; m_idx = 0;
          if (tick_i) begin m_lv0 = mem[0][1]; m_lv1 = mem[0][2]; end
          if (tick_i && reset_pin_ni) m_st = 4;
        end
        default: if (tick_i) begin
          b = mem[m_idx];
          if (m_idx == 0) begin m_wdt = b[0]; m_lv0 = b[1]; m_lv1 = b[2]; m_osc = b[4]; end
          for (int i = 0; i < 29; i++) if (t_byte(i) == m_idx) m_pu[i] = b[t_bit(i)];
          for (int p = 0; p < 8; p++) if (t_pbyte(p) == m_idx) m_flt[p] = 1'b0;
          if ((b & t_res(m_idx)) != 0) m_err = 1;
          if (m_idx == 7) begin
            if (!reset_pin_ni) m_st = 3; else begin m_st = 0; m_start = 1; end
          end else m_idx++;
        end
      endcase
      if (tick_i) m_cnt = reset_pin_ni ? 0 : (m_cnt < 3 ? m_cnt + 1 : 3);
    end
    #5;
    if (rst_ni && !done) begin
      chk("R1/R7/R9 cpu_run_o", cpu_run_o, m_st == 0);
      chk("R9/R10 hold_o", hold_o, m_st == 1 || m_st == 2);
      chk("R3 opt_rd_o", opt_rd_o, m_st == 3 || m_st == 4);
      if (opt_rd_o) chk("R3 opt_addr_o", opt_addr_o, BASE + (m_st == 4 ? m_idx : 0));
      if (opt_rd_o) chk("R11 addr in range", opt_addr_o >= 14'(BASE) && opt_addr_o <= 14'(BASE + 7), 1);
      chk("R2/R4 pin_pu_o", pin_pu_o, m_st == 3 ? 29'd0 : m_pu);
      chk("R2/R12 port_float_o", port_float_o, m_st == 3 ? 8'hFC : m_flt);
      chk("R5 wdt_en_o", wdt_en_o, m_st == 3 ? 1'b0 : m_wdt);
      chk("R6 cfg_err_o", cfg_err_o, m_st == 3 ? 1'b0 : m_err);
      chk("R2/R5 p0_level_o", p0_level_o, m_lv0);
      chk("R2/R5 p1_level_o", p1_level_o, m_lv1);
      chk("R5 osc_sel_o", osc_sel_o, m_osc);
      chk("R7 cpu_start_o", cpu_start_o, m_start);
      if (cpu_start_o) n_start++;
    end
  end

  initial begin
    int tc = 0;
    tick_i = 0;
    forever begin
      @(negedge clk_i);
      tick_i = (tc == 0);
      tc = (tc + 1) % TDIV;
    end
  end

  task automatic clocks(int n); repeat (n) @(negedge clk_i); endtask
  task automatic ticks(int n); clocks(n * TDIV); endtask
  task automatic hold_op();
    hold_instr_i = 1; ticks(1); hold_instr_i = 0;
  endtask
  task automatic load_a();
    mem[0] = 8'h13; mem[1] = 8'hA5; mem[2] = 8'h55; mem[3] = 8'h3C;
    mem[4] = 8'h09; mem[5] = 8'h00; mem[6] = 8'h00; mem[7] = 8'h0C;
  endtask
  function automatic logic [28:0] exp_pu();
    logic [28:0] e;
    for (int i = 0; i < 29; i++) e[i] = mem[t_byte(i)][t_bit(i)];
    return e;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [28:0] keep;
    int s0;
    rst_ni = 0; reset_pin_ni = 0; hold_pin_ni = 1; hold_instr_i = 0;
    load_a();
    clocks(5); rst_ni = 1;
    ticks(5);
    chk("R2 reset float", port_float_o, 8'hFC);
    chk("R2 reset cfg", pin_pu_o, 0);
    chk("R2 reset run low", cpu_run_o, 0);
    chk("R2 P0 reset level", p0_level_o, 1);
    chk("R2 P1 reset level", p1_level_o, 0);
    // first window, pattern A
    reset_pin_ni = 1; ticks(12);
    chk("R7 running", cpu_run_o, 1);
    chk("R4 pin map A", pin_pu_o, exp_pu());
    chk("R5 wdt from bit0", wdt_en_o, 1);
    chk("R5 osc from bit4", osc_sel_o, 1);
    chk("R6 no error A", cfg_err_o, 0);
    chk("R12 all released", port_float_o, 0);
    chk("R7 one start", n_start, 1);
    // short pulse ignored
    keep = pin_pu_o;
    reset_pin_ni = 0; ticks(2); reset_pin_ni = 1; ticks(4);
    chk("R1 short pulse run", cpu_run_o, 1);
    chk("R1 short pulse cfg", pin_pu_o, keep);
    // hold instruction with hold pin high
    hold_op(); ticks(1);
    chk("R9 no hold with pin high", hold_o, 0);
    // hold entry and exit
    hold_pin_ni = 0; hold_op(); ticks(1);
    chk("R9 in hold", hold_o, 1);
    chk("R9 halted", cpu_run_o, 0);
    hold_pin_ni = 1; ticks(2);
    chk("R9 resumed", cpu_run_o, 1);
    chk("R9 no start on resume", n_start, 1);
    // reset during hold, released first: dropped
    hold_pin_ni = 0; hold_op(); ticks(1);
    reset_pin_ni = 0; ticks(4); reset_pin_ni = 1; ticks(2);
    chk("R10 still hold", hold_o, 1);
    chk("R10 cfg kept", pin_pu_o, keep);
    hold_pin_ni = 1; ticks(2);
    chk("R10 resume after drop", cpu_run_o, 1);
    // reset during hold, hold ends first: taken
    hold_pin_ni = 0; hold_op(); ticks(1);
    reset_pin_ni = 0; ticks(4); hold_pin_ni = 1; ticks(2);
    chk("R10 reset taken", opt_rd_o, 1);
    chk("R10 reset cfg", pin_pu_o, 0);
    // pattern B with reserved bits set
    mem[0] = 8'h08; mem[5] = 8'h40;
    reset_pin_ni = 1; ticks(12);
    chk("R6 error set", cfg_err_o, 1);
    chk("R5 wdt off B", wdt_en_o, 0);
    chk("R7 two starts", n_start, 2);
    reset_pin_ni = 0; ticks(2); reset_pin_ni = 1; ticks(3);
    chk("R6 error sticky", cfg_err_o, 1);
    // window restart
    load_a();
    reset_pin_ni = 0; ticks(4);
    chk("R1 long pulse resets", cpu_run_o, 0);
    s0 = n_start;
    reset_pin_ni = 1; ticks(4); reset_pin_ni = 0; ticks(10);
    chk("R8 back in reset", opt_rd_o, 1);
    chk("R8 base address", opt_addr_o, BASE);
    chk("R8 no start", n_start, s0);
    reset_pin_ni = 1; ticks(12);
    chk("R7 final run", cpu_run_o, 1);
    chk("R4 pin map final", pin_pu_o, exp_pu());
    chk("R7 three starts", n_start, 3);
    ticks(2);
    finish_run();
  end
endmodule